// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block is the timekeeping core of a real-time clock. It holds a full calendar in packed BCD: seconds, minutes, hours (24-hour), day of week, date, month, two-digit year and a century count. It counts enable pulses from a 1024 Hz reference and advances the seconds once every 1024 pulses. The advance ripples through the fields within the same clock cycle. Month lengths and leap years are handled automatically.

A register window outside this block sees every field on a set of byte-wide outputs. It writes all fields at once through a parallel load port; a load also restarts the sub-second divider. Two control bits live inside the calendar bytes. One halts timekeeping; the other makes the reported seconds LSB toggle at 512 Hz, so the reference rate can be measured.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset, the seconds, minutes, hours, year and century fields read 00 and the day, date and month fields read 01. The halt bit and the test bit read 0.
- R2: With the halt bit clear, seconds advances once for every 1024 tick pulses counted from reset or from the last load; the new value appears on the outputs in the cycle after the 1024th pulse. A cycle with neither tick nor load leaves every output unchanged.
- R3: Seconds wraps 59 to 00 and advances minutes; minutes wraps 59 to 00 and advances hours; hours wraps 23 to 00 and advances both date and day of week.
- R4: Day of week counts 1 to 7 and wraps from 7 to 1 when the date advances.
- R5: Date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February; the wrap advances the month, and month 12 wraps to 01 and advances the year.
- R6: In February the last date is 29 when the BCD year is divisible by 4, including year 00, and 28 otherwise.
- R7: Year wraps 99 to 00 and advances the century; century counts 00 to 39 and wraps from 39 to 00.
- R8: A load pulse writes all fields in one cycle, clears the sub-second divider and takes priority over a tick in the same cycle. Byte layouts: seconds bits 6:0 hold the value and bit 7 the halt bit; minutes bits 6:0; hours bits 5:0; day bits 2:0 hold the weekday and bit 6 the test bit; date bits 5:0; month bits 4:0; year bits 7:0; century bits 5:0. All other bits are ignored on load and read 0.
- R9: While the halt bit is 1, ticks change no field and the divider holds its count.
- R10: While the test bit is 1 and the halt bit is 0, the seconds LSB on the output is the stored LSB XOR a phase that flips on every tick, giving a 512 Hz square wave. With either condition absent, the output shows the stored LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | Single-cycle 1024 Hz reference enable |
| loadIn | input | 1 | Parallel load strobe for all fields |
| ldSec | input | 8 | Load value: seconds and halt bit |
| ldMin | input | 8 | Load value: minutes |
| ldHour | input | 8 | Load value: hours |
| ldDay | input | 8 | Load value: weekday and test bit |
| ldDate | input | 8 | Load value: date |
| ldMonth | input | 8 | Load value: month |
| ldYear | input | 8 | Load value: year |
| ldCent | input | 8 | Load value: century |
| secOut | output | 8 | Seconds with halt bit, test toggle applied |
| minOut | output | 8 | Minutes |
| hourOut | output | 8 | Hours |
| dayOut | output | 8 | Weekday and test bit |
| dateOut | output | 8 | Date |
| monthOut | output | 8 | Month |
| yearOut | output | 8 | Year |
| centOut | output | 8 | Century |

## Verification
The properties assume that tickIn is a single-cycle pulse train and that every load carries legal BCD within each field's range. They also assume the loaded date exists in the loaded month and year. Under these assumptions, each field moves only when the field below it wraps. The random stimulus builds every load from those ranges and draws the date from the bench's own month-length function. Values are biased toward the top of each range, so the wrap chains are reached often.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

  typedef struct packed {
    logic       stop;
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic       ftest;
    logic [2:0] day;
    logic [5:0] date;
    logic [4:0] month;
    logic [7:0] year;
    logic [5:0] cent;
  } calFields_t;

  typedef struct packed {
    logic load;
    logic advSec;
  } calStrobe_t;

  // leap test on packed BCD year: multiple of 4 over 00..99
  function automatic logic isLeapBcd(input logic [7:0] yearBcd);
    logic [3:0] units;
    units = yearBcd[3:0];
    if (yearBcd[4])
      return (units == 4'd2) || (units == 4'd6);
    else
      return (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
  endfunction

  function automatic logic [5:0] monthLastDay(input logic [4:0] monthBcd,
                                              input logic [7:0] yearBcd);
    case (monthBcd)
      5'h02:                      return isLeapBcd(yearBcd) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtcc_bcd_cnt.sv
module rtcc_bcd_cnt #(
  parameter int           W     = 8,
  parameter logic [W-1:0] FIRST = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ld,
  input  logic [W-1:0] ldVal,
  input  logic         inc,
  input  logic [W-1:0] lastVal,
  output logic [W-1:0] q,
  output logic         wrap
);

  logic [7:0]   q8;
  logic [7:0]   step8;
  logic [W-1:0] nextVal;

  assign q8 = 8'(q);

  // two-digit BCD increment
  always_comb begin
    if (q8[3:0] >= 4'd9)
      step8 = {q8[7:4] + 4'd1, 4'd0};
    else
      step8 = q8 + 8'd1;
  end

  generate
    if (W < 8) begin : g_pad
      logic [7-W:0] padUnused;
      assign padUnused = step8[7:W];
    end
  endgenerate

  // out-of-range values also wrap, so a bad load cannot run away
  assign wrap    = inc && (q >= lastVal);
  assign nextVal = wrap ? FIRST : step8[W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)     q <= FIRST;
    else if (ld)   q <= ldVal;
    else if (inc)  q <= nextVal;
  end

endmodule

// File: rtl/rtcc_ctrl.sv
module rtcc_ctrl #(
  parameter int TICK_HZ = 1024,
  parameter int TEST_HZ = 512
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickIn,
  input  logic                loadIn,
  input  logic                stopQ,
  output rtcc_pkg::calStrobe_t stb,
  output logic                testPhase
);

  localparam int             DIV_W    = $clog2(TICK_HZ);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_HZ - 1);
  localparam int             TEST_BIT = $clog2(TICK_HZ / TEST_HZ) - 1;

  logic [DIV_W-1:0] subCnt;
  logic             running;
  logic             atLast;

  assign running = tickIn && !stopQ;
  assign atLast  = (subCnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)
      subCnt <= '0;
    else if (loadIn)
      subCnt <= '0;
    else if (running)
      subCnt <= atLast ? '0 : subCnt + 1'b1;
  end

  always_comb begin
    stb.load   = loadIn;
    stb.advSec = running && !loadIn && atLast;
  end

  assign testPhase = subCnt[TEST_BIT];

endmodule

// File: rtl/rtcc_datapath.sv
module rtcc_datapath #(
  parameter logic [5:0] CENT_LAST = 6'h39
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rtcc_pkg::calStrobe_t stb,
  input  rtcc_pkg::calFields_t ldVal,
  output rtcc_pkg::calFields_t cur
);

  logic [6:0] secQ, minQ;
  logic [5:0] hourQ, dateQ, centQ;
  logic [2:0] dayQ;
  logic [4:0] monthQ;
  logic [7:0] yearQ;
  logic       stopQ, ftestQ;
  logic       secWrap, minWrap, hourWrap, dateWrap, monthWrap, yearWrap;
  logic       unusedDayWrap, unusedCentWrap;
  logic [5:0] dateLast;

  assign dateLast = rtcc_pkg::monthLastDay(monthQ, yearQ);

  rtcc_bcd_cnt #(.W(7), .FIRST(7'h00)) u_sec (
    .clk(clk), .rstN(rstN), .ld(stb.load), .ldVal(ldVal.sec),
    .inc(stb.advSec), .lastVal(7'h59), .q(secQ), .wrap(secWrap));

  rtcc_bcd_cnt #(.W(7), .FIRST(7'h00)) u_min (
    .clk(clk), .rstN(rstN), .ld(stb.load), .ldVal(ldVal.min),
    .inc(secWrap), .lastVal(7'h59), .q(minQ), .wrap(minWrap));

  rtcc_bcd_cnt #(.W(6), .FIRST(6'h00)) u_hour (
    .clk(clk), .rstN(rstN), .ld(stb.load), .ldVal(ldVal.hour),
    .inc(minWrap), .lastVal(6'h23), .q(hourQ), .wrap(hourWrap));

  rtcc_bcd_cnt #(.W(3), .FIRST(3'd1)) u_day (
    .clk(clk), .rstN(rstN), .ld(stb.load), .ldVal(ldVal.day),
    .inc(hourWrap), .lastVal(3'd7), .q(dayQ), .wrap(unusedDayWrap));

  rtcc_bcd_cnt #(.W(6), .FIRST(6'h01)) u_date (
    .clk(clk), .rstN(rstN), .ld(stb.load), .ldVal(ldVal.date),
    .inc(hourWrap), .lastVal(dateLast), .q(dateQ), .wrap(dateWrap));

  rtcc_bcd_cnt #(.W(5), .FIRST(5'h01)) u_month (
    .clk(clk), .rstN(rstN), .ld(stb.load), .ldVal(ldVal.month),
    .inc(dateWrap), .lastVal(5'h12), .q(monthQ), .wrap(monthWrap));

  rtcc_bcd_cnt #(.W(8), .FIRST(8'h00)) u_year (
    .clk(clk), .rstN(rstN), .ld(stb.load), .ldVal(ldVal.year),
    .inc(monthWrap), .lastVal(8'h99), .q(yearQ), .wrap(yearWrap));

  rtcc_bcd_cnt #(.W(6), .FIRST(6'h00)) u_cent (
    .clk(clk), .rstN(rstN), .ld(stb.load), .ldVal(ldVal.cent),
    .inc(yearWrap), .lastVal(CENT_LAST), .q(centQ), .wrap(unusedCentWrap));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopQ  <= 1'b0;
      ftestQ <= 1'b0;
    end else if (stb.load) begin
      stopQ  <= ldVal.stop;
      ftestQ <= ldVal.ftest;
    end
  end

  always_comb begin
    cur.stop  = stopQ;
    cur.sec   = secQ;
    cur.min   = minQ;
    cur.hour  = hourQ;
    cur.ftest = ftestQ;
    cur.day   = dayQ;
    cur.date  = dateQ;
    cur.month = monthQ;
    cur.year  = yearQ;
    cur.cent  = centQ;
  end

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar #(
  parameter int         TICK_HZ   = 1024,
  parameter int         TEST_HZ   = 512,
  parameter logic [5:0] CENT_LAST = 6'h39
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       loadIn,
  input  logic [7:0] ldSec,
  input  logic [7:0] ldMin,
  input  logic [7:0] ldHour,
  input  logic [7:0] ldDay,
  input  logic [7:0] ldDate,
  input  logic [7:0] ldMonth,
  input  logic [7:0] ldYear,
  input  logic [7:0] ldCent,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hourOut,
  output logic [7:0] dayOut,
  output logic [7:0] dateOut,
  output logic [7:0] monthOut,
  output logic [7:0] yearOut,
  output logic [7:0] centOut
);

  rtcc_pkg::calFields_t ldVal;
  rtcc_pkg::calFields_t cur;
  rtcc_pkg::calStrobe_t stb;
  logic                 testPhase;
  logic                 unusedLdBits;
  logic                 lsbShown;

  assign unusedLdBits = ^{ldMin[7], ldHour[7:6], ldDay[7], ldDay[5:3],
                          ldDate[7:6], ldMonth[7:5], ldCent[7:6]};

  always_comb begin
    ldVal.stop  = ldSec[7];
    ldVal.sec   = ldSec[6:0];
    ldVal.min   = ldMin[6:0];
    ldVal.hour  = ldHour[5:0];
    ldVal.ftest = ldDay[6];
    ldVal.day   = ldDay[2:0];
    ldVal.date  = ldDate[5:0];
    ldVal.month = ldMonth[4:0];
    ldVal.year  = ldYear;
    ldVal.cent  = ldCent[5:0];
  end

  rtcc_ctrl #(.TICK_HZ(TICK_HZ), .TEST_HZ(TEST_HZ)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .loadIn(loadIn),
    .stopQ(cur.stop), .stb(stb), .testPhase(testPhase));

  rtcc_datapath #(.CENT_LAST(CENT_LAST)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ldVal(ldVal), .cur(cur));

  assign lsbShown = cur.sec[0] ^ (cur.ftest & ~cur.stop & testPhase);

  assign secOut   = {cur.stop, cur.sec[6:1], lsbShown};
  assign minOut   = {1'b0, cur.min};
  assign hourOut  = {2'b00, cur.hour};
  assign dayOut   = {1'b0, cur.ftest, 3'b000, cur.day};
  assign dateOut  = {2'b00, cur.date};
  assign monthOut = {3'b000, cur.month};
  assign yearOut  = cur.year;
  assign centOut  = {2'b00, cur.cent};

endmodule

// File: rtl/rtcc_chk.sv
module rtcc_chk (
  input logic                 clk,
  input logic                 rstN,
  input logic                 tickIn,
  input logic                 loadIn,
  input logic [7:0]           ldSec,
  input logic [7:0]           ldDay,
  input logic [7:0]           ldYear,
  input logic [7:0]           secOut,
  input logic [7:0]           minOut,
  input logic [7:0]           hourOut,
  input logic [7:0]           dayOut,
  input logic [7:0]           dateOut,
  input logic [7:0]           monthOut,
  input logic [7:0]           yearOut,
  input logic [7:0]           centOut,
  input rtcc_pkg::calFields_t cur,
  input rtcc_pkg::calStrobe_t stb
);

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickIn && !loadIn) |=> $stable({secOut, minOut, hourOut, dayOut,
                                       dateOut, monthOut, yearOut, centOut}));

  // R2
  sec_on_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.advSec) |=> $stable(cur.sec));

  // R3
  min_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadIn |=> (cur.min == $past(cur.min)) || (cur.sec == 7'h00));

  // R4
  dow_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadIn && cur.day == 3'd7) |=> (cur.day == 3'd7) || (cur.day == 3'd1));

  // R5
  month_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadIn |=> (cur.month == $past(cur.month)) || (cur.date == 6'h01));

  // R7
  cent_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadIn |=> (cur.cent == $past(cur.cent)) ||
                ($past(cur.year) == 8'h99 && cur.year == 8'h00));

  // R8
  load_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadIn |=> (secOut == $past(ldSec)) &&
               (dayOut == ($past(ldDay) & 8'h47)) &&
               (yearOut == $past(ldYear)));

  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cur.stop && !loadIn) |=> $stable(cur) && $stable(secOut));

  // R10
  test_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn && !loadIn && !cur.stop && cur.ftest && !stb.advSec)
      |=> (secOut[0] != $past(secOut[0])));

endmodule

bind rtc_bcd_calendar rtcc_chk u_chk (.*);

// File: tb/sim_rtc_bcd_calendar.sv
`timescale 1ns/1ps
module sim_rtc_bcd_calendar;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b0;
  logic loadIn = 1'b0;
  logic [7:0] ldSec = '0, ldMin = '0, ldHour = '0, ldDay = '0;
  logic [7:0] ldDate = '0, ldMonth = '0, ldYear = '0, ldCent = '0;
  logic [7:0] secOut, minOut, hourOut, dayOut, dateOut, monthOut, yearOut, centOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // reference model state, plain integers
  int mS, mMi, mH, mDw, mDt, mMo, mY, mC, mSub;
  bit mStop, mFt;

  always #2.5 clk = ~clk;

  rtc_bcd_calendar u0 (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .loadIn(loadIn),
    .ldSec(ldSec), .ldMin(ldMin), .ldHour(ldHour), .ldDay(ldDay),
    .ldDate(ldDate), .ldMonth(ldMonth), .ldYear(ldYear), .ldCent(ldCent),
    .secOut(secOut), .minOut(minOut), .hourOut(hourOut), .dayOut(dayOut),
    .dateOut(dateOut), .monthOut(monthOut), .yearOut(yearOut), .centOut(centOut));

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int daysIn(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic modelAdvance();
    mS++;
    if (mS == 60) begin
      mS = 0; mMi++;
      if (mMi == 60) begin
        mMi = 0; mH++;
        if (mH == 24) begin
          mH = 0;
          mDw = (mDw == 7) ? 1 : mDw + 1;
          mDt++;
          if (mDt > daysIn(mMo, mY)) begin
            mDt = 1; mMo++;
            if (mMo == 13) begin
              mMo = 1; mY++;
              if (mY == 100) begin
                mY = 0;
                mC = (mC == 39) ? 0 : mC + 1;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic modelReset();
    mS = 0; mMi = 0; mH = 0; mDw = 1; mDt = 1; mMo = 1; mY = 0; mC = 0;
    mSub = 0; mStop = 0; mFt = 0;
  endtask

  task automatic modelEdge();
    if (loadIn) begin
      mStop = ldSec[7];      mS  = b2i({1'b0, ldSec[6:0]});
      mMi   = b2i({1'b0, ldMin[6:0]});
      mH    = b2i({2'b0, ldHour[5:0]});
      mFt   = ldDay[6];      mDw = int'(ldDay[2:0]);
      mDt   = b2i({2'b0, ldDate[5:0]});
      mMo   = b2i({3'b0, ldMonth[4:0]});
      mY    = b2i(ldYear);
      mC    = b2i({2'b0, ldCent[5:0]});
      mSub  = 0;
    end else if (tickIn && !mStop) begin
      if (mSub == 1023) begin
        mSub = 0;
        modelAdvance();
      end else begin
        mSub++;
      end
    end
  endtask

  task automatic checkAll(input string tag);
    logic [7:0] sb;
    logic [63:0] expV, actV;
    sb = i2b(mS);
    expV = {mStop, sb[6:1], sb[0] ^ (mFt & ~mStop & (mSub % 2 == 1)),
            i2b(mMi), i2b(mH), {1'b0, mFt, 3'b000, 3'(mDw)},
            i2b(mDt), i2b(mMo), i2b(mY), i2b(mC)};
    actV = {secOut, minOut, hourOut, dayOut, dateOut, monthOut, yearOut, centOut};
    testsRun++;
    if (actV !== expV) begin
      testsFailed++;
      $display("FAIL %s: fields actual %h expected %h at %0t", tag, actV, expV, $time);
    end
  endtask

  // one clock: inputs set at negedge, model follows the edge, compare at next negedge
  task automatic step(input bit t, input bit l, input string tag);
    tickIn = t;
    loadIn = l;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    checkAll(tag);
    tickIn = 1'b0;
    loadIn = 1'b0;
  endtask

  task automatic loadAll(input logic [7:0] s, mi, h, d, dt, mo, y, c,
                         input bit t, input string tag);
    ldSec = s; ldMin = mi; ldHour = h; ldDay = d;
    ldDate = dt; ldMonth = mo; ldYear = y; ldCent = c;
    step(t, 1'b1, tag);
  endtask

  task automatic runTicks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, tag);
  endtask

  task automatic randomLoad();
    int mo, y, dt;
    mo = ($urandom % 3 == 0) ? 12 : 1 + $urandom % 12;
    y  = ($urandom % 3 == 0) ? 99 : $urandom % 100;
    dt = ($urandom % 2 == 0) ? daysIn(mo, y) : 1 + $urandom % daysIn(mo, y);
    loadAll({($urandom % 6 == 0) ? 1'b1 : 1'b0,
             i2b(($urandom % 2 == 0) ? 59 : $urandom % 60)[6:0]},
            i2b(($urandom % 2 == 0) ? 59 : $urandom % 60),
            i2b(($urandom % 2 == 0) ? 23 : $urandom % 24),
            {1'b0, 1'($urandom % 2), 3'b000, 3'(1 + $urandom % 7)},
            i2b(dt), i2b(mo), i2b(y),
            i2b(($urandom % 3 == 0) ? 39 : $urandom % 40),
            1'($urandom % 2), "R8");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20231));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkAll("R1");  // reset values before any edge
    step(1'b0, 1'b0, "R1");

    // R2: 1023 ticks hold, idle cycles hold, 1024th advances
    runTicks(1000, "R2");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, "R2");
    runTicks(30, "R2");

    // R3: minute and hour carries
    loadAll(8'h59, 8'h59, 8'h12, 8'h03, 8'h10, 8'h05, 8'h21, 8'h20, 1'b0, "R3");
    runTicks(1024, "R3");
    loadAll(8'h59, 8'h59, 8'h23, 8'h03, 8'h10, 8'h05, 8'h21, 8'h20, 1'b0, "R3");
    runTicks(1024, "R3");

    // R4: weekday 7 wraps to 1
    loadAll(8'h59, 8'h59, 8'h23, 8'h07, 8'h14, 8'h08, 8'h33, 8'h20, 1'b0, "R4");
    runTicks(1024, "R4");

    // R5: 30/31-day months and year carry
    loadAll(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h17, 8'h20, 1'b0, "R5");
    runTicks(1024, "R5");
    loadAll(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h01, 8'h17, 8'h20, 1'b0, "R5");
    runTicks(1024, "R5");
    loadAll(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h45, 8'h20, 1'b0, "R5");
    runTicks(1024, "R5");

    // R6: February in leap and common years
    loadAll(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h04, 8'h20, 1'b0, "R6");
    runTicks(1024, "R6");
    loadAll(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h00, 8'h20, 1'b0, "R6");
    runTicks(1024, "R6");
    loadAll(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h03, 8'h20, 1'b0, "R6");
    runTicks(1024, "R6");

    // R7: year into century, century wrap
    loadAll(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99, 8'h19, 1'b0, "R7");
    runTicks(1024, "R7");
    loadAll(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99, 8'h39, 1'b0, "R7");
    runTicks(1024, "R7");

    // R8: load beats tick, divider restarts, unused bits read 0
    runTicks(500, "R8");
    loadAll(8'h10, 8'hB4, 8'hC9, 8'hB8 | 8'h04, 8'hC7, 8'hE3, 8'h55, 8'hC2, 1'b1, "R8");
    runTicks(1024, "R8");

    // R9: halt holds every field
    loadAll(8'h80 | 8'h58, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99, 8'h39, 1'b0, "R9");
    runTicks(2100, "R9");
    loadAll(8'h58, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99, 8'h39, 1'b0, "R9");
    runTicks(1024, "R9");

    // R10: test toggle on and suppressed by halt
    loadAll(8'h07, 8'h00, 8'h00, 8'h40 | 8'h01, 8'h01, 8'h01, 8'h00, 8'h20, 1'b0, "R10");
    runTicks(16, "R10");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R10");
    loadAll(8'h87, 8'h00, 8'h00, 8'h40 | 8'h01, 8'h01, 8'h01, 8'h00, 8'h20, 1'b0, "R10");
    runTicks(16, "R10");

    // mixed random phase
    for (int i = 0; i < 90000; i++) begin
      if ($urandom % 2500 == 0) randomLoad();
      else step(($urandom % 8) != 0, 1'b0, "R2");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule